// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for one load or store and, alongside it, the new value for the base register when the instruction asks for base update. A 32-bit base register value is combined with an offset. The offset is chosen from three sources:

- a zero-extended immediate;
- an index register value;
- an index register value shifted left by a 5-bit amount.

A single adder adds the offset to the base or subtracts it from the base.

The addressing mode decides which value drives the address output and whether base update is requested:

- **Offset mode** puts the sum on the address and requests no update.
- **Pre-indexed mode** puts the sum on the address and also returns it as the new base.
- **Post-indexed mode** puts the untouched base on the address and returns the sum as the new base.

Results are registered and appear one clock after a request that has its valid input high. The decoder, the register file and the memory port sit outside the block. The update value is returned to the register file.

Top module: `lsag_top`

## Requirements
- R1: While rstN is low and on the first edge after its release, outValid, wbEn, effAddr and wbValue are all zero.
- R2: With inValid high and mode 2'b00 (offset), one clock later outValid is 1, effAddr equals base plus or minus the offset, wbValue equals the same sum and wbEn is 0.
- R3: With mode 2'b01 (pre-indexed), one clock later effAddr and wbValue both equal base plus or minus the offset and wbEn is 1.
- R4: With mode 2'b10 (post-indexed), one clock later effAddr equals the unmodified base, wbValue equals base plus or minus the offset and wbEn is 1.
- R5: srcSel 2'b00 selects the immediate input, zero-extended from IMM_W bits to 32 bits.
- R6: srcSel 2'b01 selects the index input unchanged.
- R7: srcSel 2'b10 or 2'b11 selects the index input shifted logically left by shamt (0 to 31); bits shifted past bit 31 are discarded.
- R8: subtract 1 forms base minus offset; subtract 0 forms base plus offset.
- R9: All address arithmetic wraps modulo 2^32 without any error output.
- R10: A clock with inValid low makes outValid and wbEn 0 one clock later, while effAddr and wbValue keep their previous values.
- R11: mode 2'b11 behaves exactly like offset mode (wbEn 0).
- R12: Post-indexed byte walks work when each wbValue is fed back as the next base with an immediate offset of 1. The addresses then step through consecutive bytes: base, base+1, base+2, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| base | input | DATA_W | Base register value |
| imm | input | IMM_W | Immediate offset, zero-extended |
| index | input | DATA_W | Index register value |
| shamt | input | SH_W | Left shift amount for the index |
| srcSel | input | 2 | Offset source: 00 imm, 01 index, 1x shifted index |
| subtract | input | 1 | 1 subtracts the offset, 0 adds it |
| mode | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 as offset |
| outValid | output | 1 | Registered results are valid |
| effAddr | output | DATA_W | Effective address |
| wbValue | output | DATA_W | New base value |
| wbEn | output | 1 | Base update requested |

## Verification
The bench builds the block with its defaults: a 32-bit datapath, a 12-bit immediate and therefore a 5-bit shift amount. These values make the extreme cases reachable:

- the full immediate 4095;
- a shift of 31, which pushes all but one index bit off the top;
- sums and differences that wrap past 2^32 or below zero.

All three are compared against a behavioural model every clock. A feedback loop also chains post-indexed update values through four consecutive byte addresses.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  typedef enum logic [1:0] {
    MODE_OFFSET = 2'b00,
    MODE_PRE    = 2'b01,
    MODE_POST   = 2'b10,
    MODE_ALT    = 2'b11
  } addrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new result
    logic useImm;     // offset from immediate
    logic useShift;   // index shifted left
    logic doSub;      // base minus offset
    logic addrBase;   // address is the unmodified base
    logic wbEnable;   // request base update
  } lsagCtrl_t;

endpackage

// File: rtl/lsag_ctrl.sv
module lsag_ctrl
  import lsag_pkg::*;
(
  input  logic        inValid,
  input  logic [1:0]  srcSel,
  input  logic        subtract,
  input  logic [1:0]  mode,
  output lsagCtrl_t   ctrl
);

  addrMode_e modeE;

  always_comb begin
    modeE         = addrMode_e'(mode);
    ctrl.load     = inValid;
    ctrl.useImm   = (srcSel == 2'b00);
    ctrl.useShift = srcSel[1];
    ctrl.doSub    = subtract;
    ctrl.addrBase = (modeE == MODE_POST);
    ctrl.wbEnable = inValid && ((modeE == MODE_PRE) || (modeE == MODE_POST));
  end

endmodule

// File: rtl/lsag_dp.sv
module lsag_dp
  import lsag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsagCtrl_t         ctrl,
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] index,
  input  logic [SH_W-1:0]   shamt,
  output logic              outValid,
  output logic [DATA_W-1:0] effAddr,
  output logic [DATA_W-1:0] wbValue,
  output logic              wbEn
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] idxOff;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sum;

  generate
    if (PAD_W > 0) begin : g_pad
      assign immExt = {{PAD_W{1'b0}}, imm};
    end else begin : g_nopad
      assign immExt = imm[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    idxOff = ctrl.useShift ? (index << shamt) : index;
    offset = ctrl.useImm ? immExt : idxOff;
    // single adder: subtraction through inverted addend plus carry-in
    addend = ctrl.doSub ? ~offset : offset;
    sum    = base + addend + {{(DATA_W-1){1'b0}}, ctrl.doSub};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wbEn     <= 1'b0;
      effAddr  <= '0;
      wbValue  <= '0;
    end else begin
      outValid <= ctrl.load;
      wbEn     <= ctrl.wbEnable;
      if (ctrl.load) begin
        effAddr <= ctrl.addrBase ? base : sum;
        wbValue <= sum;
      end
    end
  end

endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] index,
  input  logic [SH_W-1:0]   shamt,
  input  logic [1:0]        srcSel,
  input  logic              subtract,
  input  logic [1:0]        mode,
  output logic              outValid,
  output logic [DATA_W-1:0] effAddr,
  output logic [DATA_W-1:0] wbValue,
  output logic              wbEn
);

  lsagCtrl_t ctrl;

  lsag_ctrl u_ctrl (
    .inValid (inValid),
    .srcSel  (srcSel),
    .subtract(subtract),
    .mode    (mode),
    .ctrl    (ctrl)
  );

  lsag_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .base    (base),
    .imm     (imm),
    .index   (index),
    .shamt   (shamt),
    .outValid(outValid),
    .effAddr (effAddr),
    .wbValue (wbValue),
    .wbEn    (wbEn)
  );

endmodule

// File: rtl/lsag_chk.sv
module lsag_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] base,
  input logic [IMM_W-1:0]  imm,
  input logic [DATA_W-1:0] index,
  input logic [SH_W-1:0]   shamt,
  input logic [1:0]        srcSel,
  input logic              subtract,
  input logic [1:0]        mode,
  input logic              outValid,
  input logic [DATA_W-1:0] effAddr,
  input logic [DATA_W-1:0] wbValue,
  input logic              wbEn
);

  // R1: outputs idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !$past(rstN) |-> (!outValid && !wbEn));

  // R4: post-indexed address is the base seen one clock earlier
  p_post_base_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(mode) == 2'b10) |-> effAddr == $past(base));

  // R2 R3 R11: non-post modes put the sum on the address
  p_addr_is_sum_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(mode) != 2'b10) |-> effAddr == wbValue);

  // R2 R3 R4 R11: update requested only for pre/post requests
  p_wb_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (wbEn == ($past(inValid) && ($past(mode) == 2'b01 || $past(mode) == 2'b10))));

  // R10: idle cycle holds address outputs and drops flags
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(inValid)) |-> (!outValid && !wbEn && $stable(effAddr) && $stable(wbValue)));

  // R2: update request never without valid output
  p_wb_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> outValid);

endmodule

bind lsag_top lsag_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .base(base), .imm(imm),
  .index(index), .shamt(shamt), .srcSel(srcSel), .subtract(subtract),
  .mode(mode), .outValid(outValid), .effAddr(effAddr), .wbValue(wbValue),
  .wbEn(wbEn)
);

// File: tb/sim_lsag_top.sv
`timescale 1ns/1ps
module sim_lsag_top;

  localparam int DATA_W = 32;
  localparam int IMM_W  = 12;
  localparam int SH_W   = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] base = '0;
  logic [IMM_W-1:0]  imm = '0;
  logic [DATA_W-1:0] index = '0;
  logic [SH_W-1:0]   shamt = '0;
  logic [1:0]        srcSel = '0;
  logic              subtract = 1'b0;
  logic [1:0]        mode = '0;
  logic              outValid;
  logic [DATA_W-1:0] effAddr;
  logic [DATA_W-1:0] wbValue;
  logic              wbEn;

  int checks = 0;
  int errors = 0;
  bit modelOn = 1'b0;
  string curTag = "R1";
  string expTag = "R1";

  logic              expValid = 1'b0;
  logic              expWb = 1'b0;
  logic [DATA_W-1:0] expAddr = '0;
  logic [DATA_W-1:0] expWbVal = '0;

  always #4 clk = ~clk;  // 125 MHz

  lsag_top #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .base(base), .imm(imm),
    .index(index), .shamt(shamt), .srcSel(srcSel), .subtract(subtract),
    .mode(mode), .outValid(outValid), .effAddr(effAddr), .wbValue(wbValue),
    .wbEn(wbEn)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    logic [63:0] off;
    logic [63:0] s;
    if (!rstN) begin
      expValid = 1'b0; expWb = 1'b0; expAddr = '0; expWbVal = '0;
    end else begin
      expTag = curTag;
      expValid = inValid;
      expWb = inValid && (mode == 2'b01 || mode == 2'b10);
      if (inValid) begin
        if (srcSel == 2'b00) off = {52'd0, imm};
        else if (srcSel == 2'b01) off = {32'd0, index};
        else off = ({32'd0, index} << shamt) & 64'hFFFF_FFFF;
        if (subtract) s = {32'd0, base} - off;
        else s = {32'd0, base} + off;
        expWbVal = s[31:0];
        expAddr = (mode == 2'b10) ? base : s[31:0];
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      check(expTag, "outValid", {63'd0, outValid}, {63'd0, expValid});
      check(expTag, "wbEn", {63'd0, wbEn}, {63'd0, expWb});
      check(expTag, "effAddr", {32'd0, effAddr}, {32'd0, expAddr});
      check(expTag, "wbValue", {32'd0, wbValue}, {32'd0, expWbVal});
    end
  end

  task automatic req(input string tag, input logic v, input logic [1:0] m,
                     input logic [1:0] src, input logic sb,
                     input logic [31:0] b, input logic [11:0] im,
                     input logic [31:0] ix, input logic [4:0] sh);
    @(negedge clk);
    curTag = tag; inValid = v; mode = m; srcSel = src; subtract = sb;
    base = b; imm = im; index = ix; shamt = sh;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] walk;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "outValid", {63'd0, outValid}, 64'd0);
    check("R1", "wbEn", {63'd0, wbEn}, 64'd0);
    check("R1", "effAddr", {32'd0, effAddr}, 64'd0);
    check("R1", "wbValue", {32'd0, wbValue}, 64'd0);
    inValid = 1'b1; base = 32'h1234; mode = 2'b01;
    @(negedge clk);
    rstN = 1'b1;
    inValid = 1'b0;
    modelOn = 1'b1;
    @(negedge clk);
    check("R1", "outValid after release", {63'd0, outValid}, 64'd0);

    req("R2_R5", 1, 2'b00, 2'b00, 0, 32'h1000, 12'd20, 32'h0, 5'd0);
    req("R2_R8", 1, 2'b00, 2'b00, 1, 32'h1000, 12'hFFF, 32'h0, 5'd0);
    req("R3_R6", 1, 2'b01, 2'b01, 0, 32'h2000_0000, 12'd0, 32'h40, 5'd0);
    req("R3_R8", 1, 2'b01, 2'b01, 1, 32'h100, 12'd0, 32'h10, 5'd0);
    req("R4_R5", 1, 2'b10, 2'b00, 0, 32'hABCD_0000, 12'd4, 32'h0, 5'd0);
    req("R4_R7", 1, 2'b10, 2'b10, 0, 32'h10, 12'd0, 32'h3, 5'd2);
    req("R7", 1, 2'b00, 2'b11, 0, 32'h0, 12'd0, 32'hFFFF_FFFF, 5'd31);
    req("R7", 1, 2'b01, 2'b10, 0, 32'h5, 12'd0, 32'h8000_0001, 5'd1);
    req("R7", 1, 2'b00, 2'b10, 0, 32'h7, 12'd0, 32'h9, 5'd0);
    req("R9", 1, 2'b01, 2'b01, 0, 32'hFFFF_FFF0, 12'd0, 32'h20, 5'd0);
    req("R9", 1, 2'b00, 2'b00, 1, 32'h2, 12'd5, 32'h0, 5'd0);
    req("R11", 1, 2'b11, 2'b00, 0, 32'h300, 12'd7, 32'h0, 5'd0);
    req("R10", 0, 2'b01, 2'b01, 0, 32'hDEAD_BEEF, 12'd1, 32'h1, 5'd3);
    req("R10", 0, 2'b10, 2'b00, 1, 32'h0, 12'd9, 32'h0, 5'd0);
    req("R2", 1, 2'b00, 2'b10, 1, 32'h8000_0000, 12'd0, 32'h1, 5'd4);
    req("R10", 0, 2'b00, 2'b00, 0, 32'h0, 12'd0, 32'h0, 5'd0);
    @(negedge clk);

    // R12: post-indexed byte walk with wbValue fed back
    walk = 32'h2000_0100;
    for (int i = 0; i < 4; i++) begin
      req("R12", 1, 2'b10, 2'b00, 0, walk, 12'd1, 32'h0, 5'd0);
      @(negedge clk);
      check("R12", "walk address", {32'd0, effAddr}, {32'd0, 32'h2000_0100 + i});
      walk = wbValue;
      inValid = 1'b0;
    end
    check("R12", "final base", {32'd0, walk}, {32'd0, 32'h2000_0104});
    @(negedge clk);
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule